// File: doc/BRIEF.md
# Display Identification Fetch and Checksum Sequencer

This block reads the display identification data of an attached sink over a byte-wide request/response side channel. The side channel stands for two kinds of access. One kind is reads from the identification device on an I2C-style bus at 7-bit address 0x50. The other kind is reads and writes of the sink's own configuration registers. Each transaction moves exactly one byte. After a start pulse the sequencer first reads one byte, the extension count, which is byte 126 of block 0. It then fetches block 0, and also the extension block when that count is nonzero. Each block is 128 bytes, and the sequencer stores every byte in a local 256-byte buffer.

Each block is checked with a modulo-256 sum. A bad sum raises a warning flag but does not stop the sequence. Once the blocks are in, the sequencer reads the sink's test-request register. If the identification-read test bit is set there, it does two writes. First it writes the checksum byte of the last fetched block into the sink's test-checksum register. Then it writes the "checksum written" flag into the sink's test-response register.

If any transaction returns an error, the current attempt is abandoned and the whole sequence starts again. At most three attempts are made. The result is reported with a one-cycle done pulse, together with held pass, bad-checksum and extension-present flags. The buffer can be read at any time through a combinational read port.

Top module: `edid_fetch_seq`

## Requirements
- R1: After reset, `chReq`, `done` and `pass` are 0, and `badSum` and `extPresent` are 0.
- R2: The first transaction after a start, and the first transaction of every retry, is a read (`chWrite`=0) in identification space (`chSpace`=0) at offset 126 of device address 0x50 (`chDev`).
- R3: If the extension count is zero, offsets 0..127 are read in ascending order into buffer addresses 0..127. If it is nonzero, offsets 128..255 are then read into addresses 128..255, and `extPresent` is 1 at done.
- R4: `badSum` is 1 at done exactly when some fetched 128-byte block has a modulo-256 byte sum other than zero. A bad sum does not change the transaction sequence, and `pass` can still be 1.
- R5: After the blocks, the sink register 0x218 is read (`chSpace`=1). If bit 2 of the returned byte is set, two writes follow: buffer byte 127 (one block) or byte 255 (two blocks) goes to register 0x261, then 0x04 goes to register 0x260. If bit 2 is clear, nothing is written. Writes only ever target sink-register space.
- R6: A transaction answered with `chErr`=1 ends the current attempt, and the sequence restarts as in R2. After three failed attempts, done is signalled with `pass`=0. Success on any attempt gives `pass`=1.
- R7: `done` is high for exactly one cycle per run. `pass`, `badSum` and `extPresent` hold their values until the next accepted start.
- R8: A transaction is presented by raising `chReq` with stable `chSpace`, `chAddr`, `chWrite` and `chWdata`. It completes in the cycle where `chAck` is high, and only one transaction is outstanding at a time.
- R9: A start pulse that arrives while a run is in progress is ignored.
- R10: `rdData` equals the buffer byte at `rdAddr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; accepted only when idle |
| chReq | output | 1 | Side-channel transaction request |
| chSpace | output | 1 | 0 = identification device, 1 = sink register |
| chDev | output | 7 | Identification device address (0x50) |
| chAddr | output | 16 | Byte offset or sink register address |
| chWrite | output | 1 | 1 = write, 0 = read |
| chWdata | output | 8 | Write data |
| chAck | input | 1 | Transaction complete |
| chErr | input | 1 | Transaction failed (valid with chAck) |
| chRdata | input | 8 | Read data (valid with chAck) |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run completed without transaction error |
| badSum | output | 1 | A fetched block failed its checksum |
| extPresent | output | 1 | Extension block was fetched |
| rdAddr | input | 8 | Buffer read address |
| rdData | output | 8 | Buffer read data |

## Verification
The embedded assertions check the following on every cycle:
- request fields stay frozen until acknowledge;
- every run or retry opens with the extension-count read;
- writes go only to sink-register space;
- `done` is a single-cycle pulse;
- no byte is stored past block 0 unless an extension was announced.

Other behaviours are visible only in the bench's scenarios. These are the exact ordered transaction list under each combination of extension count and test bit, checksum verdicts on corrupted blocks, the retry count and the final failure after three errors, the ignored mid-run start, and the buffer contents.

// File: rtl/edid_seq_pkg.sv
package edid_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_EXT, ST_BLK, ST_TREQ, ST_WCS, ST_WRSP, ST_FIN
  } seqState_t;

  typedef struct packed {
    logic clearAll;
    logic captureExt;
    logic storeByte;
  } dpCtl_t;
endpackage

// File: rtl/edid_seq_dp.sv
module edid_seq_dp
  import edid_seq_pkg::*;
#(
  parameter int BLOCK_BYTES = 128,
  parameter int IDX_W = $clog2(2 * BLOCK_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [7:0]       rdByte,
  input  logic [IDX_W-1:0] rdAddr,
  output logic [IDX_W-1:0] idx,
  output logic             blockEnd,
  output logic             extFlag,
  output logic             badSum,
  output logic [7:0]       lastCsum,
  output logic [7:0]       rdData
);
  localparam int BW = $clog2(BLOCK_BYTES);
  localparam int DEPTH = 2 * BLOCK_BYTES;

  logic [7:0] buffer [DEPTH];
  logic [7:0] sum;
  logic [7:0] sumNext;

  assign sumNext  = sum + rdByte;
  assign blockEnd = (idx[BW-1:0] == {BW{1'b1}});
  // After the last store idx points one past the last block's final byte
  assign lastCsum = buffer[idx - 1'b1];
  assign rdData   = buffer[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx     <= '0;
      sum     <= '0;
      badSum  <= 1'b0;
      extFlag <= 1'b0;
    end else if (ctl.clearAll) begin
      idx     <= '0;
      sum     <= '0;
      badSum  <= 1'b0;
      extFlag <= 1'b0;
    end else begin
      if (ctl.captureExt) extFlag <= |rdByte;
      if (ctl.storeByte) begin
        idx <= idx + 1'b1;
        if (blockEnd) begin
          sum <= '0;
          if (sumNext != 8'd0) badSum <= 1'b1;
        end else begin
          sum <= sumNext;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.storeByte) buffer[idx] <= rdByte;
  end

  // R3: without an announced extension, stores stay inside block 0
  p_store_in_block0_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.storeByte && !extFlag) |-> (idx < IDX_W'(BLOCK_BYTES)));
endmodule

// File: rtl/edid_seq_ctl.sv
module edid_seq_ctl
  import edid_seq_pkg::*;
#(
  parameter int          IDX_W      = 8,
  parameter int          ADDR_W     = 16,
  parameter int          EXT_OFFSET = 126,
  parameter int          MAX_TRIES  = 3,
  parameter int          TREQ_ADDR  = 'h218,
  parameter int          TCSUM_ADDR = 'h261,
  parameter int          TRESP_ADDR = 'h260,
  parameter int          TREQ_BIT   = 2,
  parameter logic [7:0]  TRESP_VAL  = 8'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              chAck,
  input  logic              chErr,
  input  logic [7:0]        chRdata,
  input  logic [IDX_W-1:0]  idx,
  input  logic              blockEnd,
  input  logic              extFlag,
  input  logic [7:0]        lastCsum,
  output dpCtl_t            ctl,
  output logic              chReq,
  output logic              chSpace,
  output logic [ADDR_W-1:0] chAddr,
  output logic              chWrite,
  output logic [7:0]        chWdata,
  output logic              done,
  output logic              pass
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  seqState_t state, stateNext;
  logic [TRY_W-1:0] tries;
  logic triesClr, triesInc, passSet, failNow, xfer;

  assign xfer = chReq && chAck;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    triesClr  = 1'b0;
    triesInc  = 1'b0;
    passSet   = 1'b0;
    failNow   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.clearAll = 1'b1;
          triesClr     = 1'b1;
          stateNext    = ST_EXT;
        end
      end
      ST_EXT: begin
        if (xfer) begin
          if (chErr) begin
            failNow = 1'b1;
          end else begin
            ctl.captureExt = 1'b1;
            stateNext      = ST_BLK;
          end
        end
      end
      ST_BLK: begin
        if (xfer) begin
          if (chErr) begin
            failNow = 1'b1;
          end else begin
            ctl.storeByte = 1'b1;
            if (blockEnd) begin
              stateNext = (extFlag && !idx[IDX_W-1]) ? ST_BLK : ST_TREQ;
            end
          end
        end
      end
      ST_TREQ: begin
        if (xfer) begin
          if (chErr) begin
            failNow = 1'b1;
          end else if (chRdata[TREQ_BIT]) begin
            stateNext = ST_WCS;
          end else begin
            passSet   = 1'b1;
            stateNext = ST_FIN;
          end
        end
      end
      ST_WCS: begin
        if (xfer) begin
          if (chErr) failNow = 1'b1;
          else stateNext = ST_WRSP;
        end
      end
      ST_WRSP: begin
        if (xfer) begin
          if (chErr) begin
            failNow = 1'b1;
          end else begin
            passSet   = 1'b1;
            stateNext = ST_FIN;
          end
        end
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
    if (failNow) begin
      if (tries == TRY_W'(MAX_TRIES - 1)) begin
        stateNext = ST_FIN;
      end else begin
        ctl.clearAll = 1'b1;
        triesInc     = 1'b1;
        stateNext    = ST_EXT;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tries <= '0;
      pass  <= 1'b0;
    end else begin
      state <= stateNext;
      if (triesClr) tries <= '0;
      else if (triesInc) tries <= tries + 1'b1;
      if (triesClr) pass <= 1'b0;
      else if (passSet) pass <= 1'b1;
    end
  end

  always_comb begin
    chReq   = 1'b1;
    chSpace = 1'b1;
    chWrite = 1'b0;
    chWdata = 8'h00;
    chAddr  = '0;
    case (state)
      ST_EXT: begin
        chSpace = 1'b0;
        chAddr  = ADDR_W'(EXT_OFFSET);
      end
      ST_BLK: begin
        chSpace = 1'b0;
        chAddr  = {{(ADDR_W-IDX_W){1'b0}}, idx};
      end
      ST_TREQ: chAddr = ADDR_W'(TREQ_ADDR);
      ST_WCS: begin
        chAddr  = ADDR_W'(TCSUM_ADDR);
        chWrite = 1'b1;
        chWdata = lastCsum;
      end
      ST_WRSP: begin
        chAddr  = ADDR_W'(TRESP_ADDR);
        chWrite = 1'b1;
        chWdata = TRESP_VAL;
      end
      default: begin
        chReq   = 1'b0;
        chSpace = 1'b0;
      end
    endcase
  end

  assign done = (state == ST_FIN);

  // R8: request and its fields stay frozen until acknowledged
  p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (chReq && !chAck) |=> (chReq && $stable(chAddr) && $stable(chSpace)
                            && $stable(chWrite) && $stable(chWdata)));

  // R2: a fresh request always opens with the extension-count read
  p_ext_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chReq) |-> (!chSpace && !chWrite && chAddr == ADDR_W'(EXT_OFFSET)));

  // R5: writes are only issued into sink-register space
  p_write_sink_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (chReq && chWrite) |-> chSpace);

  // R7: done lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: a retry begins right after an errored completion unless tries ran out
  p_retry_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && chErr && !done && tries != TRY_W'(MAX_TRIES - 1)) |=>
      (chReq && !chSpace && chAddr == ADDR_W'(EXT_OFFSET)));
endmodule

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq
  import edid_seq_pkg::*;
#(
  parameter int          BLOCK_BYTES = 128,
  parameter int          ADDR_W      = 16,
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int          EXT_OFFSET  = 126,
  parameter int          MAX_TRIES   = 3,
  parameter int          TREQ_ADDR   = 'h218,
  parameter int          TCSUM_ADDR  = 'h261,
  parameter int          TRESP_ADDR  = 'h260,
  parameter int          TREQ_BIT    = 2,
  parameter logic [7:0]  TRESP_VAL   = 8'h04,
  localparam int         IDX_W       = $clog2(2 * BLOCK_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              chReq,
  output logic              chSpace,
  output logic [6:0]        chDev,
  output logic [ADDR_W-1:0] chAddr,
  output logic              chWrite,
  output logic [7:0]        chWdata,
  input  logic              chAck,
  input  logic              chErr,
  input  logic [7:0]        chRdata,
  output logic              done,
  output logic              pass,
  output logic              badSum,
  output logic              extPresent,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [7:0]        rdData
);
  dpCtl_t           ctl;
  logic [IDX_W-1:0] idx;
  logic             blockEnd;
  logic [7:0]       lastCsum;

  assign chDev = DEV_ADDR;

  edid_seq_ctl #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .EXT_OFFSET(EXT_OFFSET),
    .MAX_TRIES(MAX_TRIES), .TREQ_ADDR(TREQ_ADDR), .TCSUM_ADDR(TCSUM_ADDR),
    .TRESP_ADDR(TRESP_ADDR), .TREQ_BIT(TREQ_BIT), .TRESP_VAL(TRESP_VAL)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .start(start),
    .chAck(chAck), .chErr(chErr), .chRdata(chRdata),
    .idx(idx), .blockEnd(blockEnd), .extFlag(extPresent), .lastCsum(lastCsum),
    .ctl(ctl), .chReq(chReq), .chSpace(chSpace), .chAddr(chAddr),
    .chWrite(chWrite), .chWdata(chWdata), .done(done), .pass(pass)
  );

  edid_seq_dp #(
    .BLOCK_BYTES(BLOCK_BYTES), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdByte(chRdata), .rdAddr(rdAddr),
    .idx(idx), .blockEnd(blockEnd), .extFlag(extPresent), .badSum(badSum),
    .lastCsum(lastCsum), .rdData(rdData)
  );
endmodule

// File: tb/edid_fetch_seq_bench.sv
module edid_fetch_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        chReq, chSpace, chWrite;
  logic [6:0]  chDev;
  logic [15:0] chAddr;
  logic [7:0]  chWdata;
  logic        chAck = 1'b0;
  logic        chErr = 1'b0;
  logic [7:0]  chRdata = 8'h00;
  logic        done, pass, badSum, extPresent;
  logic [7:0]  rdAddr = 8'h00;
  logic [7:0]  rdData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] image [256];
  logic [7:0] testReq;
  int errIdx [3];
  int txCount;

  int logN;
  bit logSpace [1024];
  bit logWrite [1024];
  int logAddr [1024];
  logic [7:0] logData [1024];

  int expN;
  bit expSpace [1024];
  bit expWrite [1024];
  int expAddr [1024];
  logic [7:0] expData [1024];
  int gIdx;
  bit aborted;

  always #5 clk = ~clk;

  edid_fetch_seq u_edid_fetch_seq (
    .clk(clk), .rstN(rstN), .start(start),
    .chReq(chReq), .chSpace(chSpace), .chDev(chDev), .chAddr(chAddr),
    .chWrite(chWrite), .chWdata(chWdata), .chAck(chAck), .chErr(chErr),
    .chRdata(chRdata), .done(done), .pass(pass), .badSum(badSum),
    .extPresent(extPresent), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic bit isErrIdx(input int n);
    return (n == errIdx[0]) || (n == errIdx[1]) || (n == errIdx[2]);
  endfunction

  // Sink model: answers each request after 0..2 cycles
  initial begin
    forever begin
      @(negedge clk);
      chAck = 1'b0;
      chErr = 1'b0;
      if (chReq) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        if (logN < 1024) begin
          logSpace[logN] = chSpace;
          logWrite[logN] = chWrite;
          logAddr[logN]  = int'(chAddr);
          logData[logN]  = chWdata;
          logN++;
        end
        chErr = isErrIdx(txCount);
        if (!chWrite && !chSpace && chDev == 7'h50 && chAddr < 16'd256)
          chRdata = image[chAddr[7:0]];
        else if (!chWrite && chSpace && chAddr == 16'h0218)
          chRdata = testReq;
        else
          chRdata = 8'h00;
        txCount++;
        chAck = 1'b1;
      end
    end
  end

  task automatic addItem(input bit sp, input int addr, input bit wr, input logic [7:0] d);
    if (!aborted) begin
      expSpace[expN] = sp;
      expWrite[expN] = wr;
      expAddr[expN]  = addr;
      expData[expN]  = d;
      expN++;
      if (isErrIdx(gIdx)) aborted = 1;
      gIdx++;
    end
  endtask

  task automatic buildExpected(input bit ext, input bit tbit, output bit expPass);
    logic [7:0] csum;
    csum = ext ? image[255] : image[127];
    expN = 0;
    gIdx = 0;
    expPass = 0;
    for (int a = 0; a < 3; a++) begin
      aborted = 0;
      addItem(0, 126, 0, 8'h00);
      for (int i = 0; i < 128; i++) addItem(0, i, 0, 8'h00);
      if (ext) for (int i = 128; i < 256; i++) addItem(0, i, 0, 8'h00);
      addItem(1, 'h218, 0, 8'h00);
      if (tbit) begin
        addItem(1, 'h261, 1, csum);
        addItem(1, 'h260, 1, 8'h04);
      end
      if (!aborted) begin
        expPass = 1;
        break;
      end
    end
  endtask

  task automatic runScenario(input string name, input bit ext, input bit bad0, input bit bad1,
                             input bit tbit, input int e0, input int e1, input int e2,
                             input bit startMid);
    logic [7:0] s0, s1;
    bit expPass, expBad, ok;
    int wait_n;
    int firstBad;
    for (int i = 0; i < 256; i++) image[i] = 8'($urandom);
    image[126] = ext ? (8'($urandom_range(1, 255))) : 8'h00;
    s0 = 0;
    for (int i = 0; i < 127; i++) s0 += image[i];
    image[127] = -s0;
    s1 = 0;
    for (int i = 128; i < 255; i++) s1 += image[i];
    image[255] = -s1;
    if (bad0) image[5] = image[5] + 8'd1;
    if (bad1) image[200] = image[200] + 8'd3;
    s0 = 0; s1 = 0;
    for (int i = 0; i < 128; i++) s0 += image[i];
    for (int i = 128; i < 256; i++) s1 += image[i];
    expBad = (s0 != 0) || (ext && s1 != 0);
    testReq = 8'($urandom);
    testReq[2] = tbit;
    errIdx[0] = e0; errIdx[1] = e1; errIdx[2] = e2;
    txCount = 0;
    logN = 0;
    buildExpected(ext, tbit, expPass);

    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (startMid) begin
      repeat (40) @(negedge clk);
      start = 1'b1;                 // R9: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 20000) begin
      @(negedge clk);
      wait_n++;
    end
    check(done, {name, " R7 done seen"}, done, 1);

    // R3 / R5 / R6 / R9: ordered transaction list
    ok = (logN == expN);
    firstBad = -1;
    for (int i = 0; i < expN && i < logN; i++) begin
      if (firstBad < 0 && (logSpace[i] != expSpace[i] || logWrite[i] != expWrite[i] ||
          logAddr[i] != expAddr[i] || (expWrite[i] && logData[i] != expData[i])))
        firstBad = i;
    end
    if (firstBad >= 0) begin
      ok = 0;
      check(ok, {name, " R3 R5 R6 transaction"}, logAddr[firstBad] * 256 + int'(logData[firstBad]),
            expAddr[firstBad] * 256 + int'(expData[firstBad]));
    end else begin
      check(ok, {name, " R3 R5 R6 transaction count"}, logN, expN);
    end

    check(pass == expPass, {name, " R6 pass"}, pass, expPass);
    if (expPass) begin
      check(extPresent == ext, {name, " R3 extPresent"}, extPresent, ext);
      check(badSum == expBad, {name, " R4 badSum"}, badSum, expBad);
      firstBad = -1;
      for (int i = 0; i < (ext ? 256 : 128); i++) begin
        rdAddr = 8'(i);
        #1;
        if (firstBad < 0 && rdData !== image[i]) firstBad = i;
      end
      check(firstBad < 0, {name, " R10 buffer"}, firstBad, -1);
    end
    @(negedge clk);
    check(!done, {name, " R7 done single cycle"}, done, 0);
    repeat (5) @(negedge clk);
    check(pass == expPass && !done, {name, " R7 pass held"}, pass, expPass);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    logN = 0;
    txCount = 0;
    errIdx[0] = -1; errIdx[1] = -1; errIdx[2] = -1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!chReq && !done && !pass && !badSum && !extPresent, "R1 reset outputs",
          {chReq, done, pass, badSum, extPresent}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!chReq && !done, "R1 idle after reset", {chReq, done}, 0);

    runScenario("one block clean",       0, 0, 0, 0, -1, -1, -1, 0);
    runScenario("two blocks test bit",   1, 0, 0, 1, -1, -1, -1, 0);
    runScenario("bad block1",            1, 0, 1, 1, -1, -1, -1, 0);
    runScenario("bad block0",            0, 1, 0, 1, -1, -1, -1, 0);
    runScenario("retry after ext err",   1, 0, 0, 0,  0, -1, -1, 0);
    runScenario("three failures",        0, 0, 0, 1,  0,  1,  2, 0);
    runScenario("err on last write",     0, 0, 0, 1, 131, -1, -1, 0);
    runScenario("err mid block1",        1, 1, 0, 1, 200, 300, -1, 0);
    runScenario("start while busy",      1, 0, 0, 1, -1, -1, -1, 1);
    for (int k = 0; k < 6; k++) begin
      bit rext, rb0, rb1, rt;
      int re0, re1;
      rext = 1'($urandom);
      rb0 = ($urandom_range(0, 3) == 0);
      rb1 = ($urandom_range(0, 3) == 0);
      rt = 1'($urandom);
      re0 = ($urandom_range(0, 1) == 0) ? int'($urandom_range(0, 260)) : -1;
      re1 = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 520)) : -1;
      runScenario("random", rext, rb0, rb1, rt, re0, re1, -1, 0);
    end
    summary();
  end
endmodule